// File: doc/BRIEF.md
# Card Command Issue and Response Capture

This unit sends one command at a time to a memory card and records what the card answers. Software-side logic writes a 32-bit argument and a command word through a small write port. When the command word has its start bit set and its hold bit clear, the unit raises a one-cycle request towards an abstract card model, carrying the 6-bit command index and the argument. It then marks itself busy until the card signals completion.

While busy it gathers the reply bytes that the card delivers one per cycle. When the card reports completion, with an error flag and a byte count, the unit decides the outcome. That outcome is command sent (no reply wanted), reply received (a legal reply), or timeout (card error or a reply length that does not fit the request). For a legal reply it packs the bytes into up to four 32-bit words, most significant byte first. Outcome flags stay set until they are cleared through the write port.

Top module: `card_cmd_unit`

## Requirements
- R1: After reset, `status_q`, `arg_q`, `cmd_q` and `resp_flat` are all zero and `card_req` is low.
- R2: A write to address 1 with bit 10 set and bit 9 clear pulses `card_req` for exactly one cycle, with `card_idx` = written bits 5:0 and `card_arg` = `arg_q`. `status_q[11]` (busy) is high from that cycle until the cycle after `card_done`.
- R3: A write to address 1 stores bits 9:0 in `cmd_q`, and `cmd_q[10]` always reads 0. If bit 9 (hold) is set, or bit 10 is clear, no request is raised and `status_q` does not change.
- R4: With `cmd_q[6]` (reply wanted) clear, completion without error sets `status_q[7]` (sent).
- R5: With `cmd_q[6]` set, completion sets `status_q[2]` (timeout) and leaves `resp_flat` unchanged when any of these holds: the error flag is set; the length is 0; the length is 4 while `cmd_q[7]` (long) is set; the length is neither 4 nor 16.
- R6: A legal 4-byte reply sets `status_q[6]` (reply received). It puts byte 0 in bits 31:24 of word 0 through byte 3 in bits 7:0, and clears words 1 to 3. Word w sits at `resp_flat[32w+31:32w]`.
- R7: A legal 16-byte reply sets `status_q[6]` and fills words 0 to 3 from bytes 0 to 15, most significant first, with bit 0 of word 3 forced to 0. This applies even when `cmd_q[7]` is clear.
- R8: While busy, writes to every address are ignored: `arg_q`, `cmd_q` and `status_q[10:0]` keep their values and no new request is raised.
- R9: A write to address 2 clears each bit of `status_q[10:0]` whose data bit is 1 and leaves the others. Address 0 writes `arg_q`.
- R10: A reply byte delivered in the same cycle as `card_done` is part of the assembled reply.
- R11: With no reply wanted, a completion carrying the error flag sets `status_q[2]` instead of `status_q[7]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | 0 argument, 1 command, 2 status clear |
| wr_data | input | 32 | Write data |
| arg_q | output | 32 | Stored argument |
| cmd_q | output | 11 | Stored command word, start bit reads 0 |
| status_q | output | 12 | Bit 11 busy, 7 sent, 6 reply received, 2 timeout |
| resp_flat | output | 128 | Reply words 0 to 3, word 0 in the low bits |
| card_req | output | 1 | One-cycle command request to the card |
| card_idx | output | 6 | Command index |
| card_arg | output | 32 | Command argument |
| card_done | input | 1 | Card completion pulse |
| card_err | input | 1 | Card error, valid with card_done |
| card_len | input | 5 | Reply length in bytes, valid with card_done |
| card_byte_vld | input | 1 | Reply byte valid |
| card_byte | input | 8 | Reply byte |

## Verification
Two functions of the unit can fall in the same cycle: capturing a reply byte and closing the command on `card_done`. The bench provokes this by delivering the final byte of a 4-byte reply together with the completion pulse. It then judges word 0, whose low byte must hold that final byte rather than a stale buffer value. The other vectors deliver all bytes before completion, so the two paths are also compared one after the other.

// File: rtl/card_cmd_unit.sv
module card_cmd_unit #(
  parameter int WORDS = 4,
  parameter int LEN_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [31:0]          wr_data,
  output logic [31:0]          arg_q,
  output logic [10:0]          cmd_q,
  output logic [11:0]          status_q,
  output logic [WORDS*32-1:0]  resp_flat,
  output logic                 card_req,
  output logic [5:0]           card_idx,
  output logic [31:0]          card_arg,
  input  logic                 card_done,
  input  logic                 card_err,
  input  logic [LEN_W-1:0]     card_len,
  input  logic                 card_byte_vld,
  input  logic [7:0]           card_byte
);

  localparam int BYTES = WORDS * 4;
  localparam int CW    = $clog2(BYTES + 1);
  localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(4);
  localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(BYTES);

  logic [7:0]    buf_q [BYTES];
  logic [CW-1:0] cnt_q;
  logic [7:0]    byte_now [BYTES];
  logic [WORDS*32-1:0] words;

  wire busy     = status_q[11];
  wire accept   = wr_en && !busy;
  wire issue    = accept && wr_addr == 2'd1 && wr_data[10] && !wr_data[9];
  wire fin      = card_done && busy;
  wire want     = cmd_q[6];
  wire bad_len  = card_len == '0 || (card_len == LEN_SHORT && cmd_q[7]) ||
                  (card_len != LEN_SHORT && card_len != LEN_LONG);
  wire timeout  = card_err || (want && bad_len);
  wire take     = busy && card_byte_vld && cnt_q < CW'(BYTES);

  assign card_idx = cmd_q[5:0];
  assign card_arg = arg_q;

  genvar gb, gw;
  generate
    for (gb = 0; gb < BYTES; gb++) begin : g_byte
      assign byte_now[gb] = (take && cnt_q == CW'(gb)) ? card_byte : buf_q[gb];
    end
    for (gw = 0; gw < WORDS; gw++) begin : g_word
      assign words[gw*32 +: 32] = {byte_now[4*gw], byte_now[4*gw+1],
                                   byte_now[4*gw+2], byte_now[4*gw+3]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arg_q    <= '0;
      cmd_q    <= '0;
      card_req <= 1'b0;
    end else begin
      card_req <= issue;
      if (accept && wr_addr == 2'd0) arg_q <= wr_data;
      if (accept && wr_addr == 2'd1) cmd_q <= {1'b0, wr_data[9:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < BYTES; i++) buf_q[i] <= '0;
    end else if (issue) begin
      cnt_q <= '0;
    end else if (take) begin
      buf_q[cnt_q] <= card_byte;
      cnt_q        <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
    end else begin
      if (issue) status_q[11] <= 1'b1;
      if (accept && wr_addr == 2'd2) status_q[10:0] <= status_q[10:0] & ~wr_data[10:0];
      if (fin) begin
        status_q[11] <= 1'b0;
        if (timeout)   status_q[2] <= 1'b1;
        else if (want) status_q[6] <= 1'b1;
        else           status_q[7] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_flat <= '0;
    end else if (fin && want && !timeout) begin
      if (card_len == LEN_SHORT) begin
        resp_flat          <= '0;
        resp_flat[31:0]    <= words[31:0];
      end else begin
        resp_flat          <= words;
        resp_flat[(WORDS-1)*32] <= 1'b0;
      end
    end
  end

  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    card_req |=> !card_req);
  p_req_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    card_req |-> status_q[11]);
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[11] && card_done) |=> !status_q[11]);
  p_hold_regs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[11] && !card_done) |=> ($stable(arg_q) && $stable(cmd_q) && !card_req));
  p_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[11] && card_done) |=> (status_q[2] || status_q[6] || status_q[7]));
  p_bad_keeps_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[11] && card_done && cmd_q[6] && (card_err || card_len == '0)) |=> $stable(resp_flat));
  p_last_lsb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(resp_flat) |-> !resp_flat[(WORDS-1)*32]);

endmodule

// File: tb/card_cmd_unit_tb_top.sv
`timescale 1ns/1ps
module card_cmd_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] arg_q;
  logic [10:0] cmd_q;
  logic [11:0] status_q;
  logic [127:0] resp_flat;
  logic card_req;
  logic [5:0] card_idx;
  logic [31:0] card_arg;
  logic card_done = 1'b0, card_err = 1'b0, card_byte_vld = 1'b0;
  logic [4:0] card_len = '0;
  logic [7:0] card_byte = '0;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] exp_w [4];

  always #2 clk = ~clk;

  card_cmd_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .arg_q(arg_q), .cmd_q(cmd_q), .status_q(status_q), .resp_flat(resp_flat),
    .card_req(card_req), .card_idx(card_idx), .card_arg(card_arg),
    .card_done(card_done), .card_err(card_err), .card_len(card_len),
    .card_byte_vld(card_byte_vld), .card_byte(card_byte));

  // {want, long, err, len, nbytes, seed, outcome 0 sent 1 reply 2 timeout}
  localparam logic [23:0] VEC [9] = '{
    {1'b0, 1'b0, 1'b0, 5'd0,  5'd0,  8'h00, 3'd0},
    {1'b0, 1'b0, 1'b1, 5'd0,  5'd0,  8'h00, 3'd2},
    {1'b1, 1'b0, 1'b0, 5'd4,  5'd4,  8'h10, 3'd1},
    {1'b1, 1'b1, 1'b0, 5'd16, 5'd16, 8'h21, 3'd1},
    {1'b1, 1'b1, 1'b0, 5'd4,  5'd4,  8'h35, 3'd2},
    {1'b1, 1'b0, 1'b0, 5'd0,  5'd0,  8'h00, 3'd2},
    {1'b1, 1'b0, 1'b0, 5'd5,  5'd5,  8'h5a, 3'd2},
    {1'b1, 1'b0, 1'b0, 5'd16, 5'd16, 8'h43, 3'd1},
    {1'b1, 1'b0, 1'b1, 5'd4,  5'd4,  8'h66, 3'd2}
  };

  function automatic logic [7:0] bval(input logic [7:0] s, input int i);
    return s ^ 8'(i << 4);
  endfunction

  function automatic logic [31:0] wval(input logic [7:0] s, input int w);
    return {bval(s, 4*w), bval(s, 4*w+1), bval(s, 4*w+2), bval(s, 4*w+3)};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic answer(input int nb, input logic [7:0] seed, input logic err,
                        input logic [4:0] len, input bit overlap);
    @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      card_byte_vld = 1'b1; card_byte = bval(seed, k);
      if (overlap && k == nb - 1) begin
        card_done = 1'b1; card_err = err; card_len = len;
      end
      @(negedge clk);
    end
    card_byte_vld = 1'b0;
    if (!(overlap && nb > 0)) begin
      card_done = 1'b1; card_err = err; card_len = len;
      @(negedge clk);
    end
    card_done = 1'b0; card_err = 1'b0;
  endtask

  function automatic logic [127:0] expflat();
    return {exp_w[3], exp_w[2], exp_w[1], exp_w[0]};
  endfunction

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 4; w++) exp_w[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", status_q, 0);
    chk("R1 resp", resp_flat, 0);
    chk("R1 req", card_req, 0);
    chk("R1 cmd/arg", {cmd_q, arg_q}, 0);

    for (int v = 0; v < 9; v++) begin
      logic [23:0] e;
      logic [11:0] es;
      e = VEC[v];
      wr(2'd2, 32'h7ff);
      wr(2'd0, 32'hc0de_0000 + v);
      chk("R9 arg write", arg_q, 32'hc0de_0000 + v);
      wr(2'd1, {21'd0, 1'b1, 1'b0, 1'b0, e[22], e[23], 6'(v + 3)});
      chk("R2 req", card_req, 1);
      chk("R2 idx/arg", {card_idx, card_arg}, {6'(v + 3), 32'hc0de_0000 + v});
      chk("R2 busy", status_q[11], 1);
      chk("R3 start reads 0", cmd_q[10], 0);
      @(negedge clk);
      chk("R2 one-cycle req", card_req, 0);
      answer(int'(e[15:11]), e[10:3], e[21], e[20:16], 1'b0);
      es = '0;
      if (e[2:0] == 3'd0) es[7] = 1'b1;
      if (e[2:0] == 3'd1) es[6] = 1'b1;
      if (e[2:0] == 3'd2) es[2] = 1'b1;
      if (e[2:0] == 3'd1) begin
        for (int w = 0; w < 4; w++)
          exp_w[w] = (e[20:16] == 5'd4 && w > 0) ? 32'd0 : wval(e[10:3], w);
        if (e[20:16] == 5'd16) exp_w[3][0] = 1'b0;
      end
      case (e[2:0])
        3'd0: chk(e[21] ? "R11 status" : "R4 status", status_q, es);
        3'd1: chk(e[20:16] == 5'd4 ? "R6 status" : "R7 status", status_q, es);
        default: chk(e[21] && !e[23] ? "R11 status" : "R5 status", status_q, es);
      endcase
      chk(e[20:16] == 5'd16 ? "R7 words" : (e[2:0] == 3'd1 ? "R6 words" : "R5 words kept"),
          resp_flat, expflat());
    end

    // R3: hold bit set, and start bit clear
    wr(2'd2, 32'h7ff);
    wr(2'd1, 32'h0000_0605);
    chk("R3 hold no req", card_req, 0);
    chk("R3 hold status", status_q, 0);
    chk("R3 stored", cmd_q, 11'h205);
    wr(2'd1, 32'h0000_0047);
    chk("R3 no start no req", card_req, 0);
    chk("R3 no start status", status_q, 0);

    // R8: writes while busy
    wr(2'd0, 32'h1111_2222);
    wr(2'd1, 32'h0000_0409);
    chk("R8 req", card_req, 1);
    wr(2'd0, 32'h9999_9999);
    chk("R8 arg kept", arg_q, 32'h1111_2222);
    wr(2'd1, 32'h0000_0411);
    chk("R8 cmd kept", cmd_q, 11'h009);
    chk("R8 no new req", card_req, 0);
    answer(0, 8'h00, 1'b1, 5'd0, 1'b0);
    chk("R11 err no reply", status_q, 12'h004);

    // R9: selective clear
    wr(2'd2, 32'h0000_0040);
    chk("R9 other bit kept", status_q, 12'h004);
    wr(2'd2, 32'h0000_0004);
    chk("R9 cleared", status_q, 12'h000);

    // R10: last byte together with completion
    wr(2'd1, 32'h0000_0442);
    answer(4, 8'h7b, 1'b0, 5'd4, 1'b1);
    chk("R10 status", status_q, 12'h040);
    chk("R10 word0", resp_flat, {96'd0, wval(8'h7b, 0)});

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule